// File: doc/BRIEF.md
# ALU Condition Flag Generator

This block produces the negative, zero, carry and overflow condition flags for a W-bit integer datapath (32 bits by default). It forms the arithmetic result of an add, add-with-carry, subtract or subtract-with-carry from two operands, or passes through the result of a logical operation computed elsewhere. It then derives the four next-state flags and one write enable per flag. Carry and overflow do not come from an adder carry chain. They come from comparing the result with the operands, or the operands with each other. When a carry-in is consumed and the compared values are equal, the carry-in decides the outcome.

A status register inside the block takes the enabled flags at the next rising clock edge and keeps the others. The same edge registers the computed result. When the set-flags input is low, no flag changes.

Top module: `alu_flag_unit`

## Requirements
- R1: The result registered at the next clock edge, taken modulo 2^W, depends on the op select code. Code 0 (ADD) gives a+b. Code 1 (ADC) gives a+b+carry_in. Code 2 (SUB) gives a+~b+1. Code 3 (SBC) gives a+~b+carry_in. Code 4 (LOGIC) passes logic_res unchanged. Codes 5 to 7 give 0.
- R2: Flag vectors use bit 3 for N, bit 2 for Z, bit 1 for C and bit 0 for V. N is the most significant bit of the result. Z is 1 exactly when the result is zero.
- R3: For ADD, C is 1 when the result is unsigned-below a. For ADC, C is also 1 when the result equals a and carry_in is 1.
- R4: For SUB, C is 1 when a is unsigned-greater-or-equal to b, meaning no borrow occurred. For SBC, C is 1 when a is unsigned-above b, and also when a equals b and carry_in is 1.
- R5: For ADD and ADC, V is the sign bit of (res^a)&~(a^b). For SUB and SBC, V is the sign bit of (res^a)&(a^b). V equals signed two's-complement overflow.
- R6: For LOGIC, the write enables are set for N, Z and C only. C takes shift_carry. The next-state V equals the stored V.
- R7: When set_flags is low, or the op select is 5, 6 or 7, all four write enables are 0.
- R8: At each rising edge, every flag whose write enable is 1 takes its next-state value. Every other flag keeps its value.
- R9: A synchronous active-high reset clears the flag register and the registered result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| logic_res | input | W | Result of a logical operation, used when the op select is LOGIC |
| op_sel | input | 3 | Operation select (0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 LOGIC) |
| carry_in | input | 1 | Carry consumed by ADC and SBC |
| shift_carry | input | 1 | Shifter carry-out, used as C for LOGIC |
| set_flags | input | 1 | Allows the flags to update |
| nxt_flags | output | 4 | Next-state N, Z, C, V |
| flag_we | output | 4 | Write enable per flag |
| result_q | output | W | Registered result |
| flags_q | output | 4 | Registered N, Z, C, V |

## Verification
The bench builds the block with W = 4. At that width a sweep covers every pair of operands, every op select code, both carry-in values and both set-flags values. Every wrap-around, equal-operands tie and signed overflow boundary is therefore visited. The bench works out the expected carry and overflow from a widened sum and from signed integer arithmetic, not from the comparisons the design uses. This lets it catch a wrong tie rule or a swapped comparison.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_ADC   = 3'd1,
    OP_SUB   = 3'd2,
    OP_SBC   = 3'd3,
    OP_LOGIC = 3'd4
  } alu_op_e;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;
  localparam int NFLAGS = 4;
endpackage

// File: rtl/alu_result_calc.sv
module alu_result_calc
  import alu_flag_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [W-1:0]   logic_res,
  input  logic           cin,
  output logic [W-1:0]   res
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cin_w;
  assign cin_w = {{(W-1){1'b0}}, cin};

  always_comb begin
    unique case (op)
      OP_ADD:   res = a + b;
      OP_ADC:   res = a + b + cin_w;
      OP_SUB:   res = a + ~b + ONE;
      OP_SBC:   res = a + ~b + cin_w;
      OP_LOGIC: res = logic_res;
      default:  res = '0;
    endcase
  end
endmodule

// File: rtl/alu_flag_derive.sv
module alu_flag_derive
  import alu_flag_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  alu_op_e           op,
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  input  logic [W-1:0]      res,
  input  logic              cin,
  input  logic              shc,
  input  logic              set_flags,
  input  logic              cur_v,
  output logic [NFLAGS-1:0] nxt,
  output logic [NFLAGS-1:0] we
);
  logic is_add, is_sub, res_zero;
  logic c_add, c_sub, v_add, v_sub;
  logic [W-1:0] v_add_vec, v_sub_vec;

  assign is_add   = (op == OP_ADD) || (op == OP_ADC);
  assign is_sub   = (op == OP_SUB) || (op == OP_SBC);
  assign res_zero = (res == '0);

  // carry by comparison, with tie broken by carry-in for the carry-consuming forms
  always_comb begin
    c_add = (res < a);
    if (op == OP_ADC && res == a) c_add = cin;
    if (op == OP_SBC) c_sub = (a > b) || ((a == b) && cin);
    else              c_sub = (a >= b);
  end

  assign v_add_vec = (res ^ a) & ~(a ^ b);
  assign v_sub_vec = (res ^ a) & (a ^ b);
  assign v_add     = v_add_vec[W-1];
  assign v_sub     = v_sub_vec[W-1];

  always_comb begin
    nxt[FLAG_N] = res[W-1];
    nxt[FLAG_Z] = res_zero;
    nxt[FLAG_C] = 1'b0;
    nxt[FLAG_V] = cur_v;
    we          = '0;
    if (is_add) begin
      nxt[FLAG_C] = c_add;
      nxt[FLAG_V] = v_add;
      we          = {NFLAGS{set_flags}};
    end else if (is_sub) begin
      nxt[FLAG_C] = c_sub;
      nxt[FLAG_V] = v_sub;
      we          = {NFLAGS{set_flags}};
    end else if (op == OP_LOGIC) begin
      nxt[FLAG_C] = shc;
      we[FLAG_N]  = set_flags;
      we[FLAG_Z]  = set_flags;
      we[FLAG_C]  = set_flags;
    end
  end

  // R7
  no_we_without_set_chk: assert property (@(posedge clk) disable iff (rst)
    !set_flags |-> (we == '0));

  // R6
  logic_keeps_v_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LOGIC) |-> (!we[FLAG_V] && nxt[FLAG_V] == cur_v));

  // R4
  sub_zero_no_borrow_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SUB && nxt[FLAG_Z]) |-> nxt[FLAG_C]);

  // R2
  zero_not_negative_chk: assert property (@(posedge clk) disable iff (rst)
    nxt[FLAG_Z] |-> !nxt[FLAG_N]);
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_flag_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NFLAGS-1:0] we,
  input  logic [NFLAGS-1:0] nxt,
  input  logic [W-1:0]      res_in,
  output logic [NFLAGS-1:0] flags_q,
  output logic [W-1:0]      result_q
);
  for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)        flags_q[i] <= 1'b0;
      else if (we[i]) flags_q[i] <= nxt[i];
    end

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !we[i] |=> $stable(flags_q[i]));

    // R8
    flag_load_chk: assert property (@(posedge clk) disable iff (rst)
      we[i] |=> (flags_q[i] == $past(nxt[i])));
  end

  always_ff @(posedge clk) begin
    if (rst) result_q <= '0;
    else     result_q <= res_in;
  end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] logic_res,
  input  logic [2:0]   op_sel,
  input  logic         carry_in,
  input  logic         shift_carry,
  input  logic         set_flags,
  output logic [3:0]   nxt_flags,
  output logic [3:0]   flag_we,
  output logic [W-1:0] result_q,
  output logic [3:0]   flags_q
);
  alu_op_e      op;
  logic [W-1:0] res;

  assign op = alu_op_e'(op_sel);

  alu_result_calc #(.W(W)) u_calc (
    .op(op), .a(op_a), .b(op_b), .logic_res(logic_res), .cin(carry_in), .res(res)
  );

  alu_flag_derive #(.W(W)) u_derive (
    .clk(clk), .rst(rst), .op(op), .a(op_a), .b(op_b), .res(res),
    .cin(carry_in), .shc(shift_carry), .set_flags(set_flags),
    .cur_v(flags_q[FLAG_V]), .nxt(nxt_flags), .we(flag_we)
  );

  alu_flag_reg #(.W(W)) u_reg (
    .clk(clk), .rst(rst), .we(flag_we), .nxt(nxt_flags), .res_in(res),
    .flags_q(flags_q), .result_q(result_q)
  );

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (flags_q == 4'b0 && result_q == '0));
endmodule

// File: tb/tb_alu_flag_unit.sv
module tb_alu_flag_unit;
  localparam int W = 4;
  localparam int CLK_PERIOD = 10;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] op_a, op_b, logic_res;
  logic [2:0]   op_sel;
  logic         carry_in, shift_carry, set_flags;
  logic [3:0]   nxt_flags, flag_we, flags_q;
  logic [W-1:0] result_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_flag_unit #(.W(W)) dut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .logic_res(logic_res),
    .op_sel(op_sel), .carry_in(carry_in), .shift_carry(shift_carry),
    .set_flags(set_flags), .nxt_flags(nxt_flags), .flag_we(flag_we),
    .result_q(result_q), .flags_q(flags_q)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (op %0d a %0h b %0h cin %0d set %0d)",
               req, act, exp, op_sel, op_a, op_b, carry_in, set_flags);
    end
  endtask

  function automatic int sx(input int v);
    return (v >= (1 << (W-1))) ? v - (1 << W) : v;
  endfunction

  initial begin
    int exp_flags = 0;
    int exp_res   = 0;
    rst = 1'b1; op_a = '0; op_b = '0; logic_res = '0; op_sel = '0;
    carry_in = 0; shift_carry = 0; set_flags = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 flags", flags_q, 0);
    check("R9 result", result_q, 0);
    rst = 1'b0;
    for (int sf = 1; sf >= 0; sf--) begin
      for (int op = 0; op < 8; op++) begin
        for (int ci = 0; ci < 2; ci++) begin
          for (int a = 0; a <= MASK; a++) begin
            for (int b = 0; b <= MASK; b++) begin
              int s, r, c, v, sv, n, z, we, nf;
              op_a = W'(a); op_b = W'(b); op_sel = 3'(op);
              carry_in = ci[0]; set_flags = sf[0];
              logic_res = W'(a ^ b); shift_carry = b[0] ^ ci[0];
              s = 0; c = 0; v = 0;
              case (op)
                0: begin s = a + b;            sv = sx(a) + sx(b); end
                1: begin s = a + b + ci;       sv = sx(a) + sx(b) + ci; end
                2: begin s = a + (MASK - b) + 1; sv = sx(a) - sx(b); end
                3: begin s = a + (MASK - b) + ci; sv = sx(a) - sx(b) - 1 + ci; end
                4: begin s = a ^ b;            sv = 0; end
                default: begin s = 0;          sv = 0; end
              endcase
              r = s & MASK;
              if (op < 4) begin
                c = (s >> W) & 1;
                v = (sv > (1 << (W-1)) - 1 || sv < -(1 << (W-1))) ? 1 : 0;
              end else if (op == 4) begin
                c = b[0] ^ ci;
                v = exp_flags & 1;
              end
              n = (r >> (W-1)) & 1;
              z = (r == 0) ? 1 : 0;
              we = (sf == 0 || op > 4) ? 0 : (op == 4 ? 4'b1110 : 4'b1111);
              nf = (n << 3) | (z << 2) | (c << 1) | v;
              #1;
              check("R7 write enables", flag_we, we);
              if (we != 0) begin
                // R2 N and Z
                check("R2 nz", nxt_flags[3:2], nf >> 2);
                if (op < 2) check("R3 add carry", nxt_flags[1], c);
                else if (op < 4) check("R4 sub carry", nxt_flags[1], c);
                else check("R6 logic carry", nxt_flags[1], c);
                if (op < 4) check("R5 overflow", nxt_flags[0], v);
                else check("R6 v held", nxt_flags[0], v);
              end
              exp_flags = (exp_flags & ~we) | (nf & we);
              exp_res = r;
              @(negedge clk);
              check("R8 flag register", flags_q, exp_flags);
              check("R1 result", result_q, exp_res);
            end
          end
        end
      end
    end
    // R9: reset again clears state
    rst = 1'b1;
    @(negedge clk);
    check("R9 flags after reset", flags_q, 0);
    check("R9 result after reset", result_q, 0);
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule